// File: doc/BRIEF.md
# Voxel Beamforming Energy Accelerator

The block finds the backscattered energy of a single 3D voxel from radar echoes that N antennas have captured. It has one multiply-accumulate engine, and that engine is shared in time across every antenna and every filter tap. For each output index of the voxel, the engine steps through all antenna/tap pairs. For each pair it fetches a sample from the echo memory at an address shifted by that antenna's delay for this voxel, and multiplies the sample by the weight for that voxel, antenna and tap. It adds the result into a beam sum.

When the beam sum for an index is complete, the block squares it and adds the square into the voxel energy. Only the indices inside the window given with the start strobe are computed. A done pulse marks the final energy.

A voxel scheduler surrounds the block. It loads the delay and weight tables for the next voxel, pulses start with the window bounds, and collects the energy when done appears. To raise throughput, replicate the whole accelerator.

Top module: `voxel_energy_acc`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `energy_o` is 0 until the first voxel completes.
- R2: The engine visits tap k = 0..K-1 innermost, then antenna a = 0..N-1, then index n, while driving `wgt_ant_o`=a, `wgt_tap_o`=k and `dly_ant_o`=a. The sample for that pair is read at address n + d(a) - k, where d(a) is `dly_i`.
- R3: A sample address below 0 or at or above N_SAMP contributes zero. `samp_addr_o` then reads 0 and always stays below N_SAMP.
- R4: The energy is the sum, over n from win_start to win_end inclusive, of (Σa Σk w(a,k)·x(n+d(a)-k))². Samples and weights are 16-bit two's complement, and the result wraps modulo 2^64.
- R5: For a window of L = (win_end-win_start+1)·N·K pairs, `done_o` is high for exactly one cycle, L clock edges after the edge that accepts start. `energy_o` carries the new value in that cycle and holds it until the next done. A start presented in the done cycle is accepted.
- R6: If win_end < win_start, the block sets done one edge after the accepting edge, with energy 0.
- R7: A start that arrives while a voxel is in progress is ignored. Completion time and energy are unchanged.
- R8: The window bounds are captured on the accepting edge. Later changes to `win_start_i` and `win_end_i` have no effect on the voxel in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one voxel |
| win_start_i | input | IDX_W | First output index of the window |
| win_end_i | input | IDX_W | Last output index of the window (inclusive) |
| dly_ant_o | output | NW | Antenna whose delay is requested |
| dly_i | input | DLY_W | Delay of the requested antenna (same cycle) |
| wgt_ant_o | output | NW | Antenna of the requested weight |
| wgt_tap_o | output | KW | Tap of the requested weight |
| wgt_i | input | WW | Requested weight, signed (same cycle) |
| samp_addr_o | output | IDX_W | Echo memory read address |
| samp_i | input | SW | Echo sample at that address, signed (same cycle) |
| energy_o | output | E_W | Voxel energy, valid with done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs a few data patterns:
- Mixed-sign samples with staggered delays, which show whether the delay, tap and antenna indexing is correct.
- Windows that reach below address zero or past the memory end, which separate correct zero-fill from address wrap-around.
- Full-scale negative data, which drives the square past 2^64 and tests signed products and the modulo accumulation.

Window shapes cover a single index, an inverted (empty) window, a start issued in the same cycle as the previous done, and a run in which start and the bounds are disturbed part way through. Every clock, done is compared with the completion cycle predicted by the bench.

// File: rtl/vbf_pkg.sv
package vbf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EMPTY} vbf_state_e;
endpackage

// File: rtl/vbf_seq.sv
module vbf_seq
  import vbf_pkg::*;
#(
  parameter int N_ANT  = 43,
  parameter int K_TAPS = 4,
  parameter int N_SAMP = 256,
  parameter int IDX_W  = 8,
  parameter int DLY_W  = 8,
  parameter int NW     = 6,
  parameter int KW     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] win_start_i,
  input  logic [IDX_W-1:0] win_end_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [NW-1:0]    ant_o,
  output logic [KW-1:0]    tap_o,
  output logic [IDX_W-1:0] samp_addr_o,
  output logic             in_range_o,
  output logic             busy_o,
  output logic             run_o,
  output logic             clr_o,
  output logic             flush_o,
  output logic             finish_o
);
  localparam int AW = ((IDX_W > DLY_W) ? IDX_W : DLY_W) + 2;

  vbf_state_e       state_q;
  logic [IDX_W-1:0] n_q, end_q;
  logic [NW-1:0]    a_q;
  logic [KW-1:0]    k_q;
  logic             last_tap, last_ant, last_idx, accept;
  logic signed [AW-1:0] addr_s;

  assign last_tap = (k_q == KW'(K_TAPS - 1));
  assign last_ant = (a_q == NW'(N_ANT - 1));
  assign last_idx = (n_q == end_q);
  assign accept   = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      end_q   <= '0;
      a_q     <= '0;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          n_q     <= win_start_i;
          end_q   <= win_end_i;
          a_q     <= '0;
          k_q     <= '0;
          state_q <= (win_end_i < win_start_i) ? ST_EMPTY : ST_RUN;
        end
        ST_RUN: begin
          if (last_tap) begin
            k_q <= '0;
            if (last_ant) begin
              a_q <= '0;
              if (last_idx) state_q <= ST_IDLE;
              else          n_q     <= n_q + 1'b1;
            end else begin
              a_q <= a_q + 1'b1;
            end
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_EMPTY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // signed address n + d - k, negative or past end reads as zero
  assign addr_s      = AW'(n_q) + AW'(dly_i) - AW'(k_q);
  assign in_range_o  = !addr_s[AW-1] && (addr_s < $signed(AW'(N_SAMP)));
  assign samp_addr_o = in_range_o ? addr_s[IDX_W-1:0] : '0;

  assign ant_o    = a_q;
  assign tap_o    = k_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign run_o    = (state_q == ST_RUN);
  assign clr_o    = accept;
  assign flush_o  = run_o && last_tap && last_ant;
  assign finish_o = (flush_o && last_idx) || (state_q == ST_EMPTY);
endmodule

// File: rtl/vbf_mac.sv
module vbf_mac #(
  parameter int SW    = 16,
  parameter int WW    = 16,
  parameter int ACC_W = 40,
  parameter int E_W   = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 flush_i,
  input  logic                 finish_i,
  input  logic signed [SW-1:0] samp_i,
  input  logic signed [WW-1:0] wgt_i,
  output logic [E_W-1:0]       energy_o,
  output logic                 done_o
);
  localparam int PW = SW + WW;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] acc_q, beam;
  logic signed [E_W-1:0]   beam_x;
  logic [E_W-1:0]          sq, e_q, e_next;

  assign prod   = samp_i * wgt_i;
  assign beam   = acc_q + {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign beam_x = E_W'(beam);
  assign sq     = E_W'(beam_x * beam_x);  // low bits of exact square
  assign e_next = e_q + ((en_i && flush_i) ? sq : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      e_q      <= '0;
      energy_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (clr_i) begin
        acc_q <= '0;
        e_q   <= '0;
      end else if (en_i) begin
        acc_q <= flush_i ? '0 : beam;
        e_q   <= e_next;
      end
      if (finish_i) energy_o <= e_next;
    end
  end
endmodule

// File: rtl/voxel_energy_acc.sv
module voxel_energy_acc #(
  parameter int N_ANT  = 43,
  parameter int K_TAPS = 4,
  parameter int N_SAMP = 256,
  parameter int DLY_W  = 8,
  parameter int SW     = 16,
  parameter int WW     = 16,
  parameter int ACC_W  = 40,
  parameter int E_W    = 64,
  localparam int IDX_W = $clog2(N_SAMP),
  localparam int NW    = (N_ANT > 1) ? $clog2(N_ANT) : 1,
  localparam int KW    = (K_TAPS > 1) ? $clog2(K_TAPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     win_start_i,
  input  logic [IDX_W-1:0]     win_end_i,
  output logic [NW-1:0]        dly_ant_o,
  input  logic [DLY_W-1:0]     dly_i,
  output logic [NW-1:0]        wgt_ant_o,
  output logic [KW-1:0]        wgt_tap_o,
  input  logic signed [WW-1:0] wgt_i,
  output logic [IDX_W-1:0]     samp_addr_o,
  input  logic signed [SW-1:0] samp_i,
  output logic [E_W-1:0]       energy_o,
  output logic                 done_o
);
  logic [NW-1:0]        ant;
  logic [KW-1:0]        tap;
  logic                 in_range, busy, run, clr, flush, finish;
  logic signed [SW-1:0] samp_eff;

  vbf_seq #(
    .N_ANT(N_ANT), .K_TAPS(K_TAPS), .N_SAMP(N_SAMP), .IDX_W(IDX_W),
    .DLY_W(DLY_W), .NW(NW), .KW(KW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .win_start_i, .win_end_i, .dly_i,
    .ant_o(ant), .tap_o(tap), .samp_addr_o, .in_range_o(in_range),
    .busy_o(busy), .run_o(run), .clr_o(clr), .flush_o(flush),
    .finish_o(finish)
  );

  assign samp_eff  = in_range ? samp_i : '0;
  assign dly_ant_o = ant;
  assign wgt_ant_o = ant;
  assign wgt_tap_o = tap;

  vbf_mac #(.SW(SW), .WW(WW), .ACC_W(ACC_W), .E_W(E_W)) u_mac (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(run), .flush_i(flush),
    .finish_i(finish), .samp_i(samp_eff), .wgt_i, .energy_o, .done_o
  );
endmodule

// File: rtl/vbf_chk.sv
module vbf_chk #(
  parameter int N_SAMP = 256,
  parameter int K_TAPS = 4,
  parameter int IDX_W  = 8,
  parameter int NW     = 6,
  parameter int KW     = 2,
  parameter int E_W    = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             run,
  input logic             done_o,
  input logic [E_W-1:0]   energy_o,
  input logic [NW-1:0]    wgt_ant_o,
  input logic [KW-1:0]    wgt_tap_o,
  input logic [IDX_W-1:0] samp_addr_o
);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_energy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(energy_o));
  assert_done_on_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_o);
  assert_addr_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, samp_addr_o} < (IDX_W+1)'(N_SAMP));
  assert_tap_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wgt_tap_o != KW'(K_TAPS - 1)) |=>
      (wgt_tap_o == $past(wgt_tap_o) + 1'b1) && (wgt_ant_o == $past(wgt_ant_o)));
endmodule

bind voxel_energy_acc vbf_chk #(
  .N_SAMP(N_SAMP), .K_TAPS(K_TAPS), .IDX_W(IDX_W), .NW(NW), .KW(KW), .E_W(E_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .run(run), .done_o(done_o),
  .energy_o(energy_o), .wgt_ant_o(wgt_ant_o), .wgt_tap_o(wgt_tap_o),
  .samp_addr_o(samp_addr_o)
);

// File: tb/tb_voxel_energy_acc.sv
`timescale 1ns/1ps
module tb_voxel_energy_acc;
  localparam int N_ANT  = 3;
  localparam int K_TAPS = 4;
  localparam int N_SAMP = 32;
  localparam int DLY_W  = 5;
  localparam int IDX_W  = $clog2(N_SAMP);
  localparam int NW     = $clog2(N_ANT);
  localparam int KW     = $clog2(K_TAPS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [IDX_W-1:0] win_start_i = '0, win_end_i = '0;
  logic [NW-1:0] dly_ant_o, wgt_ant_o;
  logic [KW-1:0] wgt_tap_o;
  logic [DLY_W-1:0] dly_i;
  logic signed [15:0] wgt_i, samp_i;
  logic [IDX_W-1:0] samp_addr_o;
  logic [63:0] energy_o;
  logic done_o;

  logic signed [15:0] mem [N_SAMP];
  logic [DLY_W-1:0]   dly [N_ANT];
  logic signed [15:0] wgt [N_ANT][K_TAPS];

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  assign samp_i = mem[samp_addr_o];
  assign dly_i  = dly[dly_ant_o];
  assign wgt_i  = wgt[wgt_ant_o][wgt_tap_o];

  voxel_energy_acc #(.N_ANT(N_ANT), .K_TAPS(K_TAPS), .N_SAMP(N_SAMP), .DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni, .start_i, .win_start_i, .win_end_i, .dly_ant_o, .dly_i,
    .wgt_ant_o, .wgt_tap_o, .wgt_i, .samp_addr_o, .samp_i, .energy_o, .done_o);

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(int mode);
    for (int i = 0; i < N_SAMP; i++)
      mem[i] = (mode == 1) ? -16'sd32768 : 16'(((i * 7) % 23) - 11);
    for (int a = 0; a < N_ANT; a++) begin
      dly[a] = (mode == 2) ? DLY_W'(28 + a) : (mode == 1) ? DLY_W'(a) : DLY_W'(a * 3 + 1);
      for (int k = 0; k < K_TAPS; k++)
        wgt[a][k] = (mode == 1) ? -16'sd32768 : 16'(((a * 5 + k * 3) % 9) - 4);
    end
  endtask

  function automatic longint unsigned ref_energy(int ws, int we);
    longint unsigned e = 0;
    for (int n = ws; n <= we; n++) begin
      longint beam = 0;
      for (int a = 0; a < N_ANT; a++)
        for (int k = 0; k < K_TAPS; k++) begin
          int addr = n + int'(dly[a]) - k;
          if (addr >= 0 && addr < N_SAMP)
            beam += longint'(mem[addr]) * longint'(wgt[a][k]);
        end
      e += longint'(beam * beam);
    end
    return e;
  endfunction

  // drive one voxel and compare done/energy on every clock
  task automatic run_voxel(int ws, int we, bit chained, bit disturb, string req);
    longint unsigned exp_e = ref_energy(ws, we);
    int lat = (we < ws) ? 1 : (we - ws + 1) * N_ANT * K_TAPS;
    if (!chained) @(negedge clk);
    start_i = 1'b1; win_start_i = IDX_W'(ws); win_end_i = IDX_W'(we);
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, {req, " R5 early done"}, done_o, 0);
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (disturb && c == 2) begin
        start_i = 1'b1; win_start_i = '0; win_end_i = IDX_W'(N_SAMP - 1);
      end else start_i = 1'b0;
      check(done_o == (c == lat), {req, " R5 done timing"}, done_o, (c == lat));
      if (c == lat) check(energy_o == exp_e, {req, " energy"}, energy_o, exp_e);
    end
  endtask

  task automatic post_check(string req);
    longint unsigned held = energy_o;
    @(negedge clk);
    check(done_o == 1'b0, {req, " R5 pulse width"}, done_o, 0);
    check(energy_o == held, {req, " R5 energy hold"}, energy_o, held);
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    check(energy_o == 0, "R1 energy in reset", energy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0 && energy_o == 0, "R1 after release", energy_o, 0);

    run_voxel(4, 9, 0, 0, "R2 R4 staggered delays");
    post_check("R4");
    run_voxel(0, 3, 0, 0, "R3 below-zero addresses");
    post_check("R3");
    fill(2);
    run_voxel(20, 25, 0, 0, "R3 past-end addresses");
    post_check("R3");
    fill(0);
    run_voxel(7, 7, 0, 0, "R4 single index");
    post_check("R4");
    run_voxel(10, 5, 0, 0, "R6 empty window");
    run_voxel(3, 5, 1, 0, "R5 back-to-back start");
    post_check("R5");
    run_voxel(2, 6, 0, 1, "R7 R8 disturbed run");
    post_check("R7");
    fill(1);
    run_voxel(5, 8, 0, 0, "R4 full-scale wrap");
    post_check("R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule